// File: doc/BRIEF.md
# Half-Step Clock Divider

This block divides an input clock by a ratio that moves in steps of one half. A divider field `h` of parameterised width selects the ratio: for any nonzero `h` the output runs at twice the input frequency divided by `h + 1`, so the divide ratio is `(h + 1) / 2`. Field value 1 divides by one, 2 by one and a half, 3 by two, 4 by two and a half, and so on. Field value 0 is a bypass: the output is the input clock itself.

Half-step ratios put output edges on falling input edges as well as rising ones. The block therefore keeps one register clocked on each input edge and takes the output from their exclusive-or, so that exactly one register changes at any input edge. The waveform is laid out over a window of `h + 1` input cycles, which holds exactly two output periods for every ratio. A load strobe from the commit logic captures a new field value. That value is held pending and applied only where a window ends, so no short pulse is produced.

Top module: `halfstep_clkdiv`

## Requirements
- R1: `rst_i` is synchronous and active high. While it is sampled high, and until the first rising input edge after it is released, `clk_o` is low. Reset also sets the divider field to `RST_DIV` (default 3) and drops any pending load.
- R2: With a field value of 0, `clk_o` equals `clk_i`.
- R3: With an odd field value `h`, the output period is `(h + 1) / 2` input cycles. High time and low time are each `(h + 1) / 2` input half-periods.
- R4: With an even field value `h >= 2`, the output period is `h + 1` input half-periods. The high time is `(h + 2) / 2` half-periods and the low time is `h / 2`, so the duty cycle is within half an input period of 50%.
- R5: A window of `h + 1` input cycles holds two output periods. It starts at a rising input edge where `clk_o` goes high, its last half-period is low, and `clk_o` changes only at input edges.
- R6: `ld_i` samples `div_i` at a rising input edge. The new value takes effect at the first rising edge that ends the current window. Until then the waveform continues with the old value.
- R7: When several loads arrive before the window ends, the value of the last one is applied.
- R8: A load sampled at the very edge that ends a window takes effect at that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock; both edges are used |
| rst_i | input | 1 | Synchronous active-high reset |
| ld_i | input | 1 | Load strobe for a new divider field value |
| div_i | input | DIV_W | Divider field value `h` |
| clk_o | output | 1 | Divided clock |

## Verification
The assertions assume that `ld_i` and `div_i` are stable around each rising input edge, and that reset is applied for at least one rising edge before the first window starts. The bench changes inputs only in the middle of the low half of the input clock. It holds reset across several edges before releasing it, and it may re-enter reset at random mid-run only through full-cycle pulses. Random loads use any field value, including 0 and the all-ones maximum, and arrive at arbitrary points in a window. Directed cases pin a load to the window-ending edge and stack two loads within one window.

// File: rtl/hsd_pkg.sv
package hsd_pkg;

  // Output level in half-period slot k of a window made of two output
  // periods of p half-periods each: high for the first ceil(p/2) slots.
  function automatic logic hsd_level(input logic [31:0] k, input logic [31:0] p);
    logic [31:0] m;
    m = (k >= p) ? (k - p) : k;
    return ((m << 1) < p);
  endfunction

endpackage

// File: rtl/hsd_phase_cnt.sv
module hsd_phase_cnt #(
  parameter int DIV_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [DIV_W-1:0] hcur_i,
  output logic [DIV_W-1:0] cnt_o,
  output logic [DIV_W-1:0] cnt_nxt_o,
  output logic             run_o,
  output logic             wrap_o
);

  logic [DIV_W-1:0] cnt_q;
  logic             run_q;

  // A window spans hcur+1 input cycles; it ends when the count reaches hcur.
  assign wrap_o    = !run_q || (cnt_q == hcur_i);
  assign cnt_nxt_o = wrap_o ? '0 : cnt_q + 1'b1;
  assign cnt_o     = cnt_q;
  assign run_o     = run_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt_o;
      run_q <= 1'b1;
    end
  end

  // R1: reset clears the count and stops the waveform
  p_reset_clear_r1: assert property (@(posedge clk_i)
    rst_i |=> (cnt_q == '0) && !run_q);

  // R5: the cycle count never leaves the current window
  p_cnt_in_window_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    run_q |-> (cnt_q <= hcur_i));

endmodule

// File: rtl/hsd_ratio_latch.sv
module hsd_ratio_latch #(
  parameter int DIV_W   = 5,
  parameter int RST_DIV = 3
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             ld_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             wrap_i,
  output logic [DIV_W-1:0] hcur_o,
  output logic [DIV_W-1:0] hnxt_o
);

  logic [DIV_W-1:0] hcur_q;
  logic [DIV_W-1:0] pend_q;
  logic             pv_q;
  logic             take;

  // A strobe in the same cycle as the window end wins over a pending value.
  assign take   = wrap_i && (ld_i || pv_q);
  assign hnxt_o = take ? (ld_i ? div_i : pend_q) : hcur_q;
  assign hcur_o = hcur_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      hcur_q <= DIV_W'(RST_DIV);
      pend_q <= '0;
      pv_q   <= 1'b0;
    end else if (take) begin
      hcur_q <= hnxt_o;
      pv_q   <= 1'b0;
    end else if (ld_i) begin
      pend_q <= div_i;
      pv_q   <= 1'b1;
    end
  end

  // R6: the ratio is frozen inside a window
  p_hold_mid_window_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    !wrap_i |=> $stable(hcur_q));

  // R7: a strobe inside a window becomes the pending value
  p_pending_last_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    (ld_i && !wrap_i) |=> (pv_q && (pend_q == $past(div_i))));

  // R8: a strobe on the window-ending edge applies at once
  p_load_at_wrap_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (ld_i && wrap_i) |=> ((hcur_q == $past(div_i)) && !pv_q));

endmodule

// File: rtl/hsd_edge_pair.sv
module hsd_edge_pair
  import hsd_pkg::*;
#(
  parameter int DIV_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             run_i,
  input  logic             wrap_i,
  input  logic [DIV_W-1:0] cnt_i,
  input  logic [DIV_W-1:0] cnt_nxt_i,
  input  logic [DIV_W-1:0] hcur_i,
  input  logic [DIV_W-1:0] hnxt_i,
  output logic             lvl_o
);

  logic rise_q;
  logic fall_q;
  logic lvl_rise;
  logic lvl_fall;

  // Level wanted in the even slot of the coming cycle and in the odd slot
  // of the current one; the output is rise_q ^ fall_q, so each edge
  // updates only its own register and the output cannot glitch.
  assign lvl_rise = hsd_level(32'(cnt_nxt_i) << 1, 32'(hnxt_i) + 32'd1);
  assign lvl_fall = hsd_level((32'(cnt_i) << 1) + 32'd1, 32'(hcur_i) + 32'd1);

  always_ff @(posedge clk_i) begin
    if (rst_i) rise_q <= 1'b0;
    else       rise_q <= lvl_rise ^ fall_q;
  end

  always_ff @(negedge clk_i) begin
    if (!run_i) fall_q <= 1'b0;
    else        fall_q <= lvl_fall ^ rise_q;
  end

  assign lvl_o = rise_q ^ fall_q;

  // R5: the last half-period of every divided window is low
  p_window_tail_low_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (run_i && wrap_i && (hcur_i != '0)) |-> !lvl_o);

endmodule

// File: rtl/halfstep_clkdiv.sv
module halfstep_clkdiv #(
  parameter int DIV_W   = 5,
  parameter int RST_DIV = 3
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             ld_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             clk_o
);

  logic [DIV_W-1:0] hcur;
  logic [DIV_W-1:0] hnxt;
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] cnt_nxt;
  logic             run;
  logic             wrap;
  logic             lvl;
  logic             bypass;

  hsd_ratio_latch #(
    .DIV_W  (DIV_W),
    .RST_DIV(RST_DIV)
  ) u_ratio (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .ld_i  (ld_i),
    .div_i (div_i),
    .wrap_i(wrap),
    .hcur_o(hcur),
    .hnxt_o(hnxt)
  );

  hsd_phase_cnt #(
    .DIV_W(DIV_W)
  ) u_cnt (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .hcur_i   (hcur),
    .cnt_o    (cnt),
    .cnt_nxt_o(cnt_nxt),
    .run_o    (run),
    .wrap_o   (wrap)
  );

  hsd_edge_pair #(
    .DIV_W(DIV_W)
  ) u_edges (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .run_i    (run),
    .wrap_i   (wrap),
    .cnt_i    (cnt),
    .cnt_nxt_i(cnt_nxt),
    .hcur_i   (hcur),
    .hnxt_i   (hnxt),
    .lvl_o    (lvl)
  );

  assign bypass = (hcur == '0);
  assign clk_o  = run && (bypass ? clk_i : lvl);

endmodule

// File: tb/halfstep_clkdiv_bench.sv
module halfstep_clkdiv_bench;

  localparam int W    = 5;
  localparam int RSTD = 3;

  logic         clk_i = 1'b0;
  logic         rst_i = 1'b1;
  logic         ld_i  = 1'b0;
  logic [W-1:0] div_i = '0;
  logic         clk_o;

  int vecs  = 0;
  int fails = 0;
  string ctx = "R1";

  // bench-side model state
  bit mrun = 0;
  int mc   = 0;
  int mh   = RSTD;
  int mpend = 0;
  bit mpv  = 0;

  halfstep_clkdiv #(.DIV_W(W), .RST_DIV(RSTD)) u_halfstep_clkdiv (
    .clk_i(clk_i), .rst_i(rst_i), .ld_i(ld_i), .div_i(div_i), .clk_o(clk_o)
  );

  always #2 clk_i = ~clk_i;

  // Within an output period of p half-periods, high for the first (p+1)/2.
  function automatic bit exp_level(int k, int p);
    int pos;
    pos = k % p;
    return pos < ((p + 1) / 2);
  endfunction

  function automatic string mode_tag();
    if (!mrun)        return "R1";
    if (mh == 0)      return "R2";
    if (mh % 2 == 1)  return "R3";
    return "R4";
  endfunction

  task automatic check(bit expv);
    vecs++;
    if (clk_o !== expv) begin
      fails++;
      $display("FAIL %s/%s t=%0t h=%0d c=%0d clk_o=%b expected %b",
               ctx, mode_tag(), $time, mh, mc, clk_o, expv);
    end
  endtask

  task automatic model_rise(bit ld, int dv);
    bit wrap;
    if (rst_i) begin
      mrun = 0; mc = 0; mh = RSTD; mpv = 0;
    end else begin
      wrap = !mrun || (mc == mh);
      if (wrap) begin
        mc = 0;
        if (ld) begin mh = dv; mpv = 0; end
        else if (mpv) begin mh = mpend; mpv = 0; end
      end else begin
        mc++;
        if (ld) begin mpend = dv; mpv = 1; end
      end
      mrun = 1;
    end
  endtask

  // Caller is in the middle of a low input half; one full input cycle.
  task automatic step(bit ld, int dv);
    ld_i  = ld;
    div_i = W'(dv);
    @(posedge clk_i); #1;
    model_rise(ld, dv);
    check(!mrun ? 1'b0 : (mh == 0) ? 1'b1 : exp_level(2 * mc, mh + 1));
    ld_i = 1'b0;
    @(negedge clk_i); #1;
    check(!mrun ? 1'b0 : (mh == 0) ? 1'b0 : exp_level(2 * mc + 1, mh + 1));
  endtask

  task automatic run_cycles(int n);
    for (int i = 0; i < n; i++) step(1'b0, 0);
  endtask

  task automatic to_window_end();
    for (int i = 0; i < 64 && mrun && mc != mh; i++) step(1'b0, 0);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog expired at t=%0t", $time);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk_i); #1;

    // R1: reset holds output low
    ctx = "R1";
    rst_i = 1'b1;
    run_cycles(4);
    rst_i = 1'b0;
    ctx = "R3";  // reset ratio 3 -> divide by 2
    run_cycles(12);

    // R2: bypass
    ctx = "R2";
    to_window_end(); step(1'b1, 0); run_cycles(8);

    // R3: divide by 1, then by 2
    ctx = "R3";
    step(1'b1, 1); run_cycles(8);
    to_window_end(); step(1'b1, 3); run_cycles(10);

    // R4: 1.5 and 2.5
    ctx = "R4";
    to_window_end(); step(1'b1, 2); run_cycles(12);
    to_window_end(); step(1'b1, 4); run_cycles(15);

    // R6: mid-window load, old waveform continues until the window ends
    ctx = "R6";
    step(1'b0, 0); step(1'b1, 6); run_cycles(20);

    // R7: two loads inside one window, last wins
    ctx = "R7";
    to_window_end(); step(1'b0, 0); step(1'b1, 9); step(1'b1, 5); run_cycles(20);

    // R8: load exactly on the window-ending edge; also the maximum field
    ctx = "R8";
    to_window_end(); step(1'b1, (1 << W) - 1); run_cycles(70);
    to_window_end(); step(1'b1, 2); run_cycles(8);

    // R1: reset in mid-run
    ctx = "R1";
    step(1'b0, 0); rst_i = 1'b1; run_cycles(2); rst_i = 1'b0;
    ctx = "R5";
    run_cycles(8);

    // R5: random loads, values and occasional resets
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 199) == 0) rst_i = 1'b1;
      else rst_i = 1'b0;
      step($urandom_range(0, 9) == 0, $urandom_range(0, (1 << W) - 1));
    end
    rst_i = 1'b0;
    run_cycles(4);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

endmodule